// File: doc/BRIEF.md
# DRAM Compressed Parallel Test Unit

This block models the test-mode logic of a small dynamic memory. It sits between the data pins and a cell array in which every data bit has four neighbouring cells. These four cells differ only in the two lowest column address bits. The block reads the row and column strobes and the write enable on a system clock and classifies each strobe cycle. A cycle is either a normal access, a refresh with the column strobe first, or a refresh with the row strobe only. Two of these cycles change the test mode. A column-first refresh taken with write enable low turns compressed test mode on. A column-first refresh taken with write enable high, or any row-only refresh, turns it off.

In compressed mode, a write copies each data bit into all four cells of its group. A read returns one bit per data line that tells whether the four cells of the group agree. This lets a tester cover the array in a quarter of the accesses. Outside test mode, each access touches exactly one cell per data line, chosen by the full column address.

Every column-first refresh also steps an internal refresh row counter. The counter is shown on `rfsh_row` for the array's refresh logic. The data output has a separate enable that stands in for tri-stating.

Top module: `dram_tm_unit`

## Requirements
- R1: Reset (rst_n low) clears test mode and sets rfsh_row to 0. Accesses after reset are single-cell, even if test mode was active before the reset.
- R2: A cycle in which cas_n is already low when ras_n is sampled falling is a column-first refresh. If we_n is low at that sample, test mode is active from the next cycle on.
- R3: Every column-first refresh advances rfsh_row by one, the one that enters test mode included. Back-to-back column-first refreshes with we_n low keep test mode active. No other cycle changes rfsh_row.
- R4: A column-first refresh with we_n high at the ras_n fall leaves test mode.
- R5: A row-only refresh leaves test mode without changing rfsh_row. In a row-only refresh, cas_n stays high from the ras_n fall until ras_n rises.
- R6: Outside test mode, a write stores dq_in into the single word at (row, column). A read returns that word on dq_out.
- R7: In test mode, a write stores dq_in into the four words of the row whose column bits [ADDR_W-1:2] match, whatever column bits [1:0] are. Other words are unchanged.
- R8: In test mode, a read sets dq_out bit b to 1 if the four cells of bit b in the addressed group are equal, and to 0 otherwise.
- R9: dq_oe is 0 whenever cas_n is high. It is also 0 during writes and refreshes. It is 1 from the cycle after a read's cas_n fall is sampled until cas_n rises.
- R10: Reads and writes in test mode do not leave test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data or compare result, 0 while disabled |
| dq_oe | output | 1 | Output enable; low means the data pins float |
| rfsh_row | output | ADDR_W | Internal refresh row counter |

## Verification
The bench builds cell groups whose bits partly agree and partly disagree, so that a comparator which reduces across data lines, or uses AND alone, returns the wrong pattern. After leaving test mode it reads back each cell of a compressed write. A design that ignored the low column bits only partly, or spilled into other groups, would then show wrong words. Exits are tested both ways and also with back-to-back entry refreshes. A decoder that treated a row-only refresh as an access, or missed the second refresh, would then leave the wrong mode and the wrong refresh count. A reset taken while test mode is active must bring back single-cell reads and a zero counter.

// File: rtl/dram_tm_pkg.sv
package dram_tm_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_ACCESS = 2'd1,
    CYC_CBR    = 2'd2
  } cyc_e;

  // 1 when all four cells of a group hold the same value
  function automatic logic quad_agree(input logic [3:0] q);
    return (&q) | ~(|q);
  endfunction

endpackage

// File: rtl/dram_tm_decode.sv
module dram_tm_decode
  import dram_tm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output logic              cbr_evt,
  output logic              ras_only_evt,
  output logic              access_evt,
  output logic              rd_act,
  output logic              tm,
  output logic [ADDR_W-1:0] rfsh_row
);

  logic ras_q, cas_q, cas_seen_q;
  cyc_e cyc_q;
  logic ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;

  assign cbr_evt      = ras_fall & ~cas_n;
  assign access_evt   = cas_fall & ~ras_n & ~ras_q & (cyc_q == CYC_ACCESS);
  assign ras_only_evt = ras_rise & (cyc_q == CYC_ACCESS) & ~cas_seen_q & cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      cas_seen_q <= 1'b0;
      cyc_q      <= CYC_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      rd_act     <= 1'b0;
      tm         <= 1'b0;
      rfsh_row   <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;

      if (ras_fall) begin
        row_q <= addr;
        cyc_q <= cas_n ? CYC_ACCESS : CYC_CBR;
      end else if (ras_rise) begin
        cyc_q <= CYC_IDLE;
      end

      if (ras_fall)            cas_seen_q <= 1'b0;
      else if (!cas_n && !ras_n) cas_seen_q <= 1'b1;

      if (cbr_evt) begin
        tm       <= ~we_n;
        rfsh_row <= rfsh_row + 1'b1;
      end else if (ras_only_evt) begin
        tm <= 1'b0;
      end

      if (access_evt) begin
        col_q  <= addr;
        rd_act <= we_n;
      end else if (cas_n || ras_n) begin
        rd_act <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dram_tm_array.sv
module dram_tm_array
  import dram_tm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              tm,
  input  logic [ADDR_W-1:0] row,
  input  logic [ADDR_W-1:0] wr_col,
  input  logic [ADDR_W-1:0] rd_col,
  input  logic [DQ_W-1:0]   din,
  output logic [DQ_W-1:0]   dout
);

  localparam int ROWS = 1 << ADDR_W;
  localparam int COLS = 1 << ADDR_W;
  localparam int GRP  = 4;

  logic [DQ_W-1:0] mem [ROWS][COLS];

  // compressed writes fan one word out to the whole group
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < GRP; k++) begin
        if (tm || (wr_col[1:0] == 2'(k)))
          mem[row][{wr_col[ADDR_W-1:2], 2'(k)}] <= din;
      end
    end
  end

  for (genvar b = 0; b < DQ_W; b++) begin : g_bit
    logic [GRP-1:0] quad;
    always_comb begin
      for (int k = 0; k < GRP; k++)
        quad[k] = mem[row][{rd_col[ADDR_W-1:2], 2'(k)}][b];
    end
    assign dout[b] = tm ? quad_agree(quad) : mem[row][rd_col][b];
  end

endmodule

// File: rtl/dram_tm_unit.sv
module dram_tm_unit #(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] rfsh_row
);

  logic [ADDR_W-1:0] row_q, col_q;
  logic cbr_evt, ras_only_evt, access_evt, rd_act, tm_flag;
  logic wr_en;
  logic [DQ_W-1:0] rd_data;

  dram_tm_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .row_q(row_q), .col_q(col_q), .cbr_evt(cbr_evt),
    .ras_only_evt(ras_only_evt), .access_evt(access_evt), .rd_act(rd_act),
    .tm(tm_flag), .rfsh_row(rfsh_row)
  );

  assign wr_en = access_evt & ~we_n;

  dram_tm_array #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_array (
    .clk(clk), .wr_en(wr_en), .tm(tm_flag), .row(row_q), .wr_col(addr),
    .rd_col(col_q), .din(dq_in), .dout(rd_data)
  );

  assign dq_oe  = rd_act & ~cas_n;
  assign dq_out = dq_oe ? rd_data : '0;

endmodule

// File: rtl/dram_tm_chk.sv
module dram_tm_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic              cbr_evt,
  input logic              ras_only_evt,
  input logic              access_evt,
  input logic              tm_flag,
  input logic [ADDR_W-1:0] rfsh_row
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (rfsh_row == '0) && !tm_flag);

  // R2
  tm_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_evt && !we_n) |=> tm_flag);

  // R3
  rfsh_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_evt |=> rfsh_row == ADDR_W'($past(rfsh_row) + 1));

  // R3
  rfsh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cbr_evt |=> $stable(rfsh_row));

  // R4
  tm_exit_cbr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_evt && we_n) |=> !tm_flag);

  // R5
  tm_exit_ras_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_only_evt |=> !tm_flag);

  // R9
  oe_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_n |-> !dq_oe);

  // R10
  tm_access_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    access_evt |=> tm_flag == $past(tm_flag));

  // R2
  cycle_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cbr_evt, ras_only_evt, access_evt}));

endmodule

bind dram_tm_unit dram_tm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .we_n(we_n), .dq_oe(dq_oe),
  .cbr_evt(cbr_evt), .ras_only_evt(ras_only_evt), .access_evt(access_evt),
  .tm_flag(tm_flag), .rfsh_row(rfsh_row)
);

// File: tb/test_dram_tm_unit.sv
module test_dram_tm_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 4;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_CBR0 = 3'd2,
                         OP_CBR1 = 3'd3, OP_RO = 3'd4;

  typedef struct packed {
    logic [2:0] op;
    logic [3:0] row;
    logic [3:0] col;
    logic [3:0] dat;
    logic [3:0] exp;   // read data, or rfsh_row after a refresh
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{OP_WR,   4'd1, 4'd0,  4'hA, 4'h0},  // R6
    '{OP_WR,   4'd1, 4'd1,  4'h5, 4'h0},
    '{OP_RD,   4'd1, 4'd0,  4'h0, 4'hA},  // R6
    '{OP_RD,   4'd1, 4'd1,  4'h0, 4'h5},  // R6
    '{OP_WR,   4'd2, 4'd4,  4'hF, 4'h0},
    '{OP_WR,   4'd2, 4'd5,  4'hF, 4'h0},
    '{OP_WR,   4'd2, 4'd6,  4'h0, 4'h0},
    '{OP_WR,   4'd2, 4'd7,  4'hF, 4'h0},
    '{OP_WR,   4'd6, 4'd4,  4'h3, 4'h0},
    '{OP_WR,   4'd6, 4'd5,  4'h3, 4'h0},
    '{OP_WR,   4'd6, 4'd6,  4'h1, 4'h0},
    '{OP_WR,   4'd6, 4'd7,  4'h3, 4'h0},
    '{OP_CBR0, 4'd0, 4'd0,  4'h0, 4'h1},  // R2 R3 entry
    '{OP_RD,   4'd2, 4'd5,  4'h0, 4'h0},  // R8 all bits disagree
    '{OP_RD,   4'd6, 4'd7,  4'h0, 4'hD},  // R8 bit1 disagrees only
    '{OP_WR,   4'd3, 4'd9,  4'h6, 4'h0},  // R7
    '{OP_RD,   4'd3, 4'd10, 4'h0, 4'hF},  // R8 all agree
    '{OP_WR,   4'd2, 4'd12, 4'h9, 4'h0},  // R10
    '{OP_RD,   4'd2, 4'd15, 4'h0, 4'hF},  // R10
    '{OP_CBR1, 4'd0, 4'd0,  4'h0, 4'h2},  // R4 exit
    '{OP_RD,   4'd3, 4'd8,  4'h0, 4'h6},  // R7
    '{OP_RD,   4'd3, 4'd11, 4'h0, 4'h6},  // R7
    '{OP_RD,   4'd2, 4'd13, 4'h0, 4'h9},  // R7
    '{OP_RD,   4'd1, 4'd0,  4'h0, 4'hA},  // R7 other group untouched
    '{OP_CBR0, 4'd0, 4'd0,  4'h0, 4'h3},
    '{OP_RO,   4'd0, 4'd0,  4'h0, 4'h3},  // R5 no count
    '{OP_RD,   4'd3, 4'd9,  4'h0, 4'h6},  // R5 single-cell again
    '{OP_CBR0, 4'd0, 4'd0,  4'h0, 4'h4},
    '{OP_CBR0, 4'd0, 4'd0,  4'h0, 4'h5},  // R3 back-to-back
    '{OP_WR,   4'd4, 4'd0,  4'h3, 4'h0},
    '{OP_RD,   4'd4, 4'd2,  4'h0, 4'hF},  // R3 still in test mode
    '{OP_CBR1, 4'd0, 4'd0,  4'h0, 4'h6},
    '{OP_RD,   4'd4, 4'd3,  4'h0, 4'h3}   // R7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;
  logic [AW-1:0] rfsh_row;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_tm_unit #(.ADDR_W(AW), .DQ_W(DW)) i_dram_tm_unit (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rfsh_row(rfsh_row)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] row, input logic [3:0] col, input logic [3:0] d);
    @(negedge clk); addr = row; ras_n = 1'b0;
    @(negedge clk); addr = col; we_n = 1'b0; dq_in = d; cas_n = 1'b0;
    @(negedge clk); chk(8'(dq_oe), 8'h0, "R9 oe during write");
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [3:0] row, input logic [3:0] col, output logic [3:0] d);
    @(negedge clk); addr = row; ras_n = 1'b0;
    @(negedge clk); addr = col; we_n = 1'b1; cas_n = 1'b0;
    @(negedge clk); d = dq_out;
    chk(8'(dq_oe), 8'h1, "R9 oe during read");
    cas_n = 1'b1; ras_n = 1'b1;
    #1 chk(8'(dq_oe), 8'h0, "R9 oe after cas high");
    @(negedge clk);
  endtask

  task automatic do_cbr(input logic w);
    @(negedge clk); cas_n = 1'b0; we_n = w;
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); chk(8'(dq_oe), 8'h0, "R9 oe during refresh");
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_ras_only(input logic [3:0] row);
    @(negedge clk); addr = row; ras_n = 1'b0;
    @(negedge clk);
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(8'(rfsh_row), 8'h0, "R1 rfsh_row at reset");
    chk(8'(dq_oe), 8'h0, "R1 oe at reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: do_write(VEC[i].row, VEC[i].col, VEC[i].dat);
        OP_RD: begin
          do_read(VEC[i].row, VEC[i].col, rd);
          chk(8'(rd), 8'(VEC[i].exp), $sformatf("R6/R7/R8/R10 read vector %0d", i));
        end
        OP_CBR0, OP_CBR1: begin
          do_cbr(VEC[i].op == OP_CBR1);
          chk(8'(rfsh_row), 8'(VEC[i].exp), $sformatf("R2/R3/R4 refresh count vector %0d", i));
        end
        default: begin
          do_ras_only(VEC[i].row);
          chk(8'(rfsh_row), 8'(VEC[i].exp), $sformatf("R5 refresh count vector %0d", i));
        end
      endcase
    end

    // R1: reset while test mode is active
    do_cbr(1'b0);
    chk(8'(rfsh_row), 8'h7, "R3 count before reset");
    do_write(4'd7, 4'd4, 4'hF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(8'(rfsh_row), 8'h0, "R1 rfsh_row after reset");
    chk(8'(dq_oe), 8'h0, "R1 oe after reset");
    rst_n = 1'b1;
    @(negedge clk);
    do_write(4'd7, 4'd5, 4'h0);
    do_read(4'd7, 4'd4, rd);
    chk(8'(rd), 8'hF, "R1 single-cell read after reset");
    do_read(4'd7, 4'd5, rd);
    chk(8'(rd), 8'h0, "R1 single-cell write after reset");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule